// File: doc/BRIEF.md
# Parallel Longest-Prefix Lookup Engine Controller

This block accepts 32-bit destination addresses with a caller-supplied tag and hands each one to one of up to eight lookup engines working in parallel. Each engine walks a four-level trie of 8-bit strides held in an external memory. All engines share a single read port to that memory, and the port is pipelined. While one engine waits for its read data, other engines issue their own reads, so several lookups are in progress at once. This raises throughput without adding memory.

The number of engines in use is set at runtime through a small configuration register and defaults to four. Addresses go to the lowest-numbered idle engine that is enabled. Memory reads are granted round-robin among the engines that want the port. Each read carries the index of its engine down a tag pipeline as deep as the fixed memory latency, so the returned word reaches the engine that asked for it. Finished lookups leave on a single result port with their tag. Results can therefore leave in a different order from the addresses. Two counters report completed lookups and cycles with work in progress, for throughput measurement.

Each engine is a four-state machine:
- ENG_IDLE: the engine is free.
- ENG_REQ: the engine wants the memory port.
- ENG_WAIT: the engine's read is in flight.
- ENG_DONE: the engine holds a result.

The transitions are:
- dispatch: ENG_IDLE to ENG_REQ, when an address is handed over.
- grant: ENG_REQ to ENG_WAIT, when the engine wins the port.
- descend: ENG_WAIT to ENG_REQ, when the returned node has a child and the level is not the last.
- finish: ENG_WAIT to ENG_DONE, in all other cases when the data returns.
- deliver: ENG_DONE to ENG_IDLE, when the result collector takes the result.

Top module: `lpm_engine_ctrl`

## Requirements
- R1: The enable count resets to 4. A cycle with `cfg_we` high loads `cfg_count` as the count n, which enables engines 0..n-1. A value of 0 acts as 1, and values above 8 act as 8. `req_ready` goes low once every enabled engine is busy.
- R2: An accepted address (`req_valid` and `req_ready` high at a clock edge) goes to the lowest-numbered idle enabled engine. Disabled engines never receive work. `res_engine` reports the index of the engine that served the lookup.
- R3: A lookup reads levels k = 0..3 at memory address {ptr, byte k}. The value ptr is 0 at level 0, and byte k is address bits 31-8k down to 24-8k. A node word has these fields: bit 15 is child present, bit 14 is hop present, bits 13:8 are the hop, and bits 7:0 are the child pointer. The walk stops at a node without a child, or after level 3. The result is the hop of the deepest node that has one, or 0 if no node has one.
- R4: At most one memory read is issued per cycle, granted round-robin among the engines in ENG_REQ. The total number of reads equals the total number of levels visited.
- R5: Read data arrives exactly 3 cycles (`LAT`) after its read and goes only to the engine that issued that read.
- R6: Every accepted address produces exactly one result carrying its tag. Results may leave out of order. When several engines finish together, the lowest-numbered engine delivers first and the others hold their results.
- R7: With no contention, a lookup that visits L levels shows `res_valid` L*(LAT+1) clock edges after its acceptance edge. It stays in ENG_DONE for one cycle.
- R8: Lowering the enable count affects only new dispatches. Lookups already running on engines that are now disabled still complete with correct results.
- R9: `lookup_count` counts delivered results. `busy_cycles` counts cycles in which any engine is not idle. Both are 0 after reset, and both hold while all engines are idle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_we | input | 1 | Load the enable count |
| cfg_count | input | 4 | New enable count (clamped to 1..8) |
| req_valid | input | 1 | Address offered |
| req_addr | input | 32 | Destination address |
| req_tag | input | 8 | Caller tag for the address |
| req_ready | output | 1 | An enabled engine is idle |
| mem_rd | output | 1 | Memory read strobe |
| mem_addr | output | 16 | Memory word address {ptr, byte} |
| mem_rdata | input | 16 | Node word, LAT cycles after the read |
| res_valid | output | 1 | Result present this cycle |
| res_engine | output | 3 | Engine that served the lookup |
| res_hop | output | 6 | Next hop found (0 = no route) |
| res_tag | output | 8 | Tag of the finished address |
| lookup_count | output | 32 | Delivered results |
| busy_cycles | output | 32 | Cycles with any engine not idle |

## Verification
A misrouted read-data word or a wrong round-robin pointer gives a wrong next hop for some tag. It can also leave a lookup without a result, or change the total number of memory strobes against the sum of levels the bench computes. These symptoms appear as soon as the first lookup affected completes, a few tens of cycles after the bad read. A fault in the dispatch or enable logic shows up within the first batch after a configuration change, because the bench checks which engine served each lookup and when `req_ready` drops. Timing faults in an engine's states change the exact latency of an isolated lookup, or the `busy_cycles` total over a run of isolated lookups.

// File: rtl/lpm_pkg.sv
package lpm_pkg;
    localparam int ADDRW  = 32;
    localparam int STRIDE = 8;
    localparam int LEVELS = ADDRW / STRIDE;
    localparam int LVLW   = $clog2(LEVELS);
    localparam int PTRW   = 8;
    localparam int HOPW   = 6;
    localparam int MAW    = PTRW + STRIDE;
    localparam int MDW    = 2 + HOPW + PTRW;

    typedef enum logic [1:0] {
        ENG_IDLE = 2'd0,
        ENG_REQ  = 2'd1,
        ENG_WAIT = 2'd2,
        ENG_DONE = 2'd3
    } eng_state_e;

    typedef struct packed {
        logic            has_child;
        logic            has_hop;
        logic [HOPW-1:0] hop;
        logic [PTRW-1:0] child;
    } node_t;
endpackage

// File: rtl/lpm_walk_engine.sv
module lpm_walk_engine
    import lpm_pkg::*;
#(
    parameter int TW = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start,
    input  logic [ADDRW-1:0] start_addr,
    input  logic [TW-1:0]    start_tag,
    input  logic             grant,
    input  logic             rd_valid,
    input  logic [MDW-1:0]   rd_data,
    input  logic             res_ack,
    output logic             idle,
    output logic             want_mem,
    output logic             done,
    output logic             busy,
    output logic [MAW-1:0]   mem_addr,
    output logic [HOPW-1:0]  res_hop,
    output logic [TW-1:0]    res_tag
);
    eng_state_e        state_q, state_d;
    logic [ADDRW-1:0]  addr_q;
    logic [TW-1:0]     tag_q;
    logic [LVLW-1:0]   lvl_q;
    logic [PTRW-1:0]   ptr_q;
    logic [HOPW-1:0]   hop_q;
    logic [STRIDE-1:0] cur_byte;
    node_t             node;
    logic              last_lvl;
    logic              descend;

    assign node     = node_t'(rd_data);
    assign last_lvl = (lvl_q == LVLW'(LEVELS - 1));
    assign descend  = node.has_child && !last_lvl;
    assign cur_byte = addr_q[ADDRW - STRIDE - STRIDE * int'(lvl_q) +: STRIDE];

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= ENG_IDLE;
        else        state_q <= state_d;
    end

    // transitions: dispatch, grant, descend, finish, deliver
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ENG_IDLE: if (start)    state_d = ENG_REQ;
            ENG_REQ:  if (grant)    state_d = ENG_WAIT;
            ENG_WAIT: if (rd_valid) state_d = descend ? ENG_REQ : ENG_DONE;
            ENG_DONE: if (res_ack)  state_d = ENG_IDLE;
            default:                state_d = ENG_IDLE;
        endcase
    end

    // walk datapath
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            addr_q <= '0;
            tag_q  <= '0;
            lvl_q  <= '0;
            ptr_q  <= '0;
            hop_q  <= '0;
        end else if (state_q == ENG_IDLE && start) begin
            addr_q <= start_addr;
            tag_q  <= start_tag;
            lvl_q  <= '0;
            ptr_q  <= '0;
            hop_q  <= '0;
        end else if (state_q == ENG_WAIT && rd_valid) begin
            if (node.has_hop) hop_q <= node.hop;
            if (descend) begin
                ptr_q <= node.child;
                lvl_q <= lvl_q + 1'b1;
            end
        end
    end

    // outputs
    always_comb begin
        idle     = (state_q == ENG_IDLE);
        want_mem = (state_q == ENG_REQ);
        done     = (state_q == ENG_DONE);
        busy     = (state_q != ENG_IDLE);
        mem_addr = {ptr_q, cur_byte};
        res_hop  = hop_q;
        res_tag  = tag_q;
    end

    assert_start_when_idle_R2: assert property (@(posedge clk) disable iff (!rst_n)
        start |-> state_q == ENG_IDLE);
    assert_data_in_wait_R5: assert property (@(posedge clk) disable iff (!rst_n)
        rd_valid |-> state_q == ENG_WAIT);
    assert_ack_done_R6: assert property (@(posedge clk) disable iff (!rst_n)
        res_ack |-> state_q == ENG_DONE);
endmodule

// File: rtl/lpm_mem_arb.sv
module lpm_mem_arb #(
    parameter int N   = 8,
    parameter int LAT = 3,
    localparam int IW = (N > 1) ? $clog2(N) : 1
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [N-1:0]  req,
    output logic [N-1:0]  gnt,
    output logic          gnt_any,
    output logic [IW-1:0] gnt_idx,
    output logic [N-1:0]  rd_route
);
    logic [IW-1:0]  rr_q;
    logic [LAT-1:0] pv_q;
    logic [IW-1:0]  pidx_q [LAT];

    // round-robin pick starting at the pointer
    always_comb begin
        gnt     = '0;
        gnt_any = 1'b0;
        gnt_idx = '0;
        for (int off = 0; off < N; off++) begin
            int idx;
            idx = int'(rr_q) + off;
            if (idx >= N) idx = idx - N;
            if (!gnt_any && req[idx]) begin
                gnt[idx] = 1'b1;
                gnt_any  = 1'b1;
                gnt_idx  = IW'(idx);
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n)       rr_q <= '0;
        else if (gnt_any) rr_q <= (int'(gnt_idx) == N - 1) ? '0 : gnt_idx + 1'b1;
    end

    // engine-index pipeline matching the memory latency
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pv_q <= '0;
            for (int s = 0; s < LAT; s++) pidx_q[s] <= '0;
        end else begin
            pv_q[0]   <= gnt_any;
            pidx_q[0] <= gnt_idx;
            for (int s = 1; s < LAT; s++) begin
                pv_q[s]   <= pv_q[s-1];
                pidx_q[s] <= pidx_q[s-1];
            end
        end
    end

    always_comb begin
        rd_route = '0;
        if (pv_q[LAT-1]) rd_route[pidx_q[LAT-1]] = 1'b1;
    end

    assert_one_grant_R4: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(gnt));
endmodule

// File: rtl/lpm_result_collect.sv
module lpm_result_collect
    import lpm_pkg::*;
#(
    parameter int N  = 8,
    parameter int TW = 8,
    localparam int IW = (N > 1) ? $clog2(N) : 1
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic [N-1:0]    done,
    input  logic [HOPW-1:0] hops [N],
    input  logic [TW-1:0]   tags [N],
    input  logic            any_busy,
    output logic [N-1:0]    ack,
    output logic            res_valid,
    output logic [IW-1:0]   res_engine,
    output logic [HOPW-1:0] res_hop,
    output logic [TW-1:0]   res_tag,
    output logic [31:0]     lookup_count,
    output logic [31:0]     busy_cycles
);
    // lowest-numbered finished engine wins
    always_comb begin
        ack        = '0;
        res_valid  = 1'b0;
        res_engine = '0;
        res_hop    = '0;
        res_tag    = '0;
        for (int i = N - 1; i >= 0; i--) begin
            if (done[i]) begin
                res_valid  = 1'b1;
                res_engine = IW'(i);
                res_hop    = hops[i];
                res_tag    = tags[i];
            end
        end
        if (res_valid) ack[res_engine] = 1'b1;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            lookup_count <= '0;
            busy_cycles  <= '0;
        end else begin
            if (res_valid) lookup_count <= lookup_count + 1;
            if (any_busy)  busy_cycles  <= busy_cycles + 1;
        end
    end

    assert_busy_stable_R9: assert property (@(posedge clk) disable iff (!rst_n)
        !any_busy |=> $stable(busy_cycles));
endmodule

// File: rtl/lpm_engine_ctrl.sv
module lpm_engine_ctrl
    import lpm_pkg::*;
#(
    parameter int NENG    = 8,
    parameter int DEF_ENG = 4,
    parameter int LAT     = 3,
    parameter int TW      = 8,
    localparam int IW = (NENG > 1) ? $clog2(NENG) : 1,
    localparam int CW = $clog2(NENG + 1)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             cfg_we,
    input  logic [CW-1:0]    cfg_count,
    input  logic             req_valid,
    input  logic [ADDRW-1:0] req_addr,
    input  logic [TW-1:0]    req_tag,
    output logic             req_ready,
    output logic             mem_rd,
    output logic [MAW-1:0]   mem_addr,
    input  logic [MDW-1:0]   mem_rdata,
    output logic             res_valid,
    output logic [IW-1:0]    res_engine,
    output logic [HOPW-1:0]  res_hop,
    output logic [TW-1:0]    res_tag,
    output logic [31:0]      lookup_count,
    output logic [31:0]      busy_cycles
);
    logic [CW-1:0]   cnt_q;
    logic [NENG-1:0] en_mask, eng_idle, eng_req, eng_done, eng_busy;
    logic [NENG-1:0] start_vec, gnt_vec, route_vec, ack_vec;
    logic [MAW-1:0]  eng_addr [NENG];
    logic [HOPW-1:0] eng_hop  [NENG];
    logic [TW-1:0]   eng_tag  [NENG];
    logic            gnt_any;
    logic [IW-1:0]   gnt_idx;

    // enable count register, clamped to 1..NENG
    always_ff @(posedge clk) begin
        if (!rst_n) cnt_q <= CW'(DEF_ENG);
        else if (cfg_we) begin
            if (cfg_count == '0)                cnt_q <= CW'(1);
            else if (int'(cfg_count) > NENG)    cnt_q <= CW'(NENG);
            else                                cnt_q <= cfg_count;
        end
    end

    always_comb begin
        for (int i = 0; i < NENG; i++) en_mask[i] = (i < int'(cnt_q));
    end

    // dispatch to lowest idle enabled engine
    always_comb begin
        logic found;
        found     = 1'b0;
        start_vec = '0;
        for (int i = 0; i < NENG; i++) begin
            if (!found && eng_idle[i] && en_mask[i]) begin
                found        = 1'b1;
                start_vec[i] = req_valid;
            end
        end
        req_ready = found;
    end

    for (genvar g = 0; g < NENG; g++) begin : g_eng
        lpm_walk_engine #(.TW(TW)) u_eng (
            .clk        (clk),
            .rst_n      (rst_n),
            .start      (start_vec[g]),
            .start_addr (req_addr),
            .start_tag  (req_tag),
            .grant      (gnt_vec[g]),
            .rd_valid   (route_vec[g]),
            .rd_data    (mem_rdata),
            .res_ack    (ack_vec[g]),
            .idle       (eng_idle[g]),
            .want_mem   (eng_req[g]),
            .done       (eng_done[g]),
            .busy       (eng_busy[g]),
            .mem_addr   (eng_addr[g]),
            .res_hop    (eng_hop[g]),
            .res_tag    (eng_tag[g])
        );
    end

    lpm_mem_arb #(.N(NENG), .LAT(LAT)) u_arb (
        .clk      (clk),
        .rst_n    (rst_n),
        .req      (eng_req),
        .gnt      (gnt_vec),
        .gnt_any  (gnt_any),
        .gnt_idx  (gnt_idx),
        .rd_route (route_vec)
    );

    assign mem_rd   = gnt_any;
    assign mem_addr = eng_addr[gnt_idx];

    lpm_result_collect #(.N(NENG), .TW(TW)) u_col (
        .clk          (clk),
        .rst_n        (rst_n),
        .done         (eng_done),
        .hops         (eng_hop),
        .tags         (eng_tag),
        .any_busy     (|eng_busy),
        .ack          (ack_vec),
        .res_valid    (res_valid),
        .res_engine   (res_engine),
        .res_hop      (res_hop),
        .res_tag      (res_tag),
        .lookup_count (lookup_count),
        .busy_cycles  (busy_cycles)
    );

    assert_ready_needs_enabled_idle_R1: assert property (@(posedge clk) disable iff (!rst_n)
        req_ready |-> (eng_idle & en_mask) != '0);
endmodule

// File: tb/lpm_engine_ctrl_test.sv
`timescale 1ns/1ps
module lpm_engine_ctrl_test;
    localparam int LAT = 3;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cfg_we = 1'b0;
    logic [3:0]  cfg_count = '0;
    logic        req_valid = 1'b0;
    logic [31:0] req_addr = '0;
    logic [7:0]  req_tag = '0;
    logic        req_ready, mem_rd, res_valid;
    logic [15:0] mem_addr, mem_rdata;
    logic [2:0]  res_engine;
    logic [5:0]  res_hop;
    logic [7:0]  res_tag;
    logic [31:0] lookup_count, busy_cycles;

    always #2 clk = ~clk;

    lpm_engine_ctrl uut (
        .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_count(cfg_count),
        .req_valid(req_valid), .req_addr(req_addr), .req_tag(req_tag), .req_ready(req_ready),
        .mem_rd(mem_rd), .mem_addr(mem_addr), .mem_rdata(mem_rdata),
        .res_valid(res_valid), .res_engine(res_engine), .res_hop(res_hop), .res_tag(res_tag),
        .lookup_count(lookup_count), .busy_cycles(busy_cycles)
    );

    int checks = 0, fails = 0;
    int cyc = 0, nrd = 0, sent = 0, rcvd = 0, total_rcvd = 0;
    logic [5:0] e_hop [256];
    int e_lv [256], e_exact [256], e_bound [256], acc [256], rcyc [256];
    bit got [256];
    logic [31:0] seed = 32'h1234_5678;

    // memory model: node word as a function of its address, LAT-cycle pipeline
    function automatic logic [15:0] node_at(input logic [15:0] a);
        logic [7:0] ch;
        ch = a[7:0] + a[15:8] + 8'h35;
        return {(a[3] ^ a[9]) | a[12], a[5] | a[0], a[13:8] ^ a[5:0], ch};
    endfunction

    logic [15:0] mpipe [LAT];
    always @(posedge clk) begin
        mpipe[0] <= mem_rd ? node_at(mem_addr) : 16'h0;
        for (int s = 1; s < LAT; s++) mpipe[s] <= mpipe[s-1];
    end
    assign mem_rdata = mpipe[LAT-1];

    always @(posedge clk) cyc <= cyc + 1;

    task automatic chk(input bit ok, input string rq, input string what, input int act, input int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s %s actual=%0d expected=%0d", rq, what, act, exp);
        end
    endtask

    task automatic finish_run;
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    endtask

    // walk model from R3
    task automatic walk(input logic [31:0] a, output logic [5:0] hop, output int lv);
        logic [7:0] ptr;
        logic [15:0] w;
        ptr = 8'h0; hop = 6'h0; lv = 0;
        for (int k = 0; k < 4; k++) begin
            w = node_at({ptr, a[31 - 8*k -: 8]});
            lv++;
            if (w[14]) hop = w[13:8];
            if (!w[15]) break;
            ptr = w[7:0];
        end
    endtask

    // result monitor
    always @(negedge clk) begin
        if (rst_n && mem_rd) nrd++;
        if (rst_n && res_valid) begin
            int t;
            t = int'(res_tag);
            chk(!got[t], "R6", "duplicate result tag", t, -1);
            chk(res_hop == e_hop[t], "R3", "next hop", int'(res_hop), int'(e_hop[t]));
            chk(int'(res_engine) < e_bound[t], "R2", "engine within enable count", int'(res_engine), e_bound[t] - 1);
            if (e_exact[t] >= 0)
                chk(int'(res_engine) == e_exact[t], "R2", "lowest idle engine", int'(res_engine), e_exact[t]);
            got[t] = 1'b1;
            rcyc[t] = cyc;
            rcvd++;
            total_rcvd++;
        end
    end

    task automatic new_phase;
        for (int i = 0; i < 256; i++) begin
            got[i] = 1'b0; e_exact[i] = -1; e_bound[i] = 8;
        end
        sent = 0; rcvd = 0; nrd = 0;
    endtask

    task automatic send(input logic [31:0] a, input int t, input int bound, input int exact);
        logic [5:0] h;
        int lv;
        walk(a, h, lv);
        e_hop[t] = h; e_lv[t] = lv; e_bound[t] = bound; e_exact[t] = exact;
        forever begin
            @(negedge clk);
            req_valid = 1'b1; req_addr = a; req_tag = 8'(t);
            if (req_ready) break;
        end
        @(posedge clk);
        #1 req_valid = 1'b0;
        acc[t] = cyc;
        sent++;
    endtask

    task automatic set_count(input int v);
        @(negedge clk);
        cfg_we = 1'b1; cfg_count = 4'(v);
        @(posedge clk);
        #1 cfg_we = 1'b0;
    endtask

    task automatic drain(input string rq);
        int lv_sum;
        while (rcvd < sent) @(negedge clk);
        @(negedge clk);
        lv_sum = 0;
        for (int t = 0; t < sent; t++) begin
            chk(got[t], "R6", "result missing for tag", t, t);
            lv_sum += e_lv[t];
        end
        chk(nrd == lv_sum, "R4", {"memory reads equal levels visited ", rq}, nrd, lv_sum);
    endtask

    function automatic logic [31:0] next_addr();
        seed = seed * 32'd1664525 + 32'd1013904223;
        return seed;
    endfunction

    initial begin
        repeat (150000) @(posedge clk);
        checks++; fails++;
        $display("FAIL R6 watchdog expired actual=%0d expected=%0d", cyc, 150000);
        finish_run();
    end

    initial begin
        int b0, l0, exp_busy;
        new_phase();
        repeat (3) @(posedge clk);
        #1 rst_n = 1'b1;
        @(negedge clk);
        chk(req_ready == 1'b1, "R1", "ready after reset", int'(req_ready), 1);
        chk(res_valid == 1'b0, "R6", "no result after reset", int'(res_valid), 0);
        chk(lookup_count == 0, "R9", "lookup_count after reset", int'(lookup_count), 0);
        chk(busy_cycles == 0, "R9", "busy_cycles after reset", int'(busy_cycles), 0);

        // R1 default of four engines
        new_phase();
        for (int k = 0; k < 4; k++) send(next_addr(), k, 4, k);
        @(negedge clk);
        chk(req_ready == 1'b0, "R1", "ready low with four default engines busy", int'(req_ready), 0);
        send(next_addr(), 4, 4, -1);
        drain("default");

        // R7 isolated latency with one engine; R9 busy total
        set_count(1);
        new_phase();
        b0 = int'(busy_cycles);
        exp_busy = 0;
        for (int k = 0; k < 8; k++) begin
            send(next_addr(), k, 1, 0);
            drain("isolated");
            chk(rcyc[k] - acc[k] == e_lv[k] * (LAT + 1), "R7", "isolated latency",
                rcyc[k] - acc[k], e_lv[k] * (LAT + 1));
            exp_busy += e_lv[k] * (LAT + 1) + 1;
        end
        chk(int'(busy_cycles) - b0 == exp_busy, "R9", "busy cycles over isolated lookups",
            int'(busy_cycles) - b0, exp_busy);

        // R1/R2/R4/R5 sweep over every configuration value
        for (int v = 0; v < 16; v++) begin
            int eff;
            eff = (v == 0) ? 1 : (v > 8 ? 8 : v);
            set_count(v);
            new_phase();
            for (int k = 0; k < 20; k++) begin
                send(next_addr(), k, eff, (k < eff && k < 5) ? k : -1);
                if (k == eff - 1 && eff <= 4) begin
                    @(negedge clk);
                    chk(req_ready == 1'b0, "R1", "ready low with all enabled engines busy", int'(req_ready), 0);
                end
            end
            drain("sweep");
        end

        // R8 lower the count while all eight run
        set_count(8);
        new_phase();
        for (int k = 0; k < 8; k++) send(next_addr(), k, 8, (k < 5) ? k : -1);
        set_count(2);
        for (int k = 8; k < 14; k++) send(next_addr(), k, 2, -1);
        drain("reduce");
        for (int k = 0; k < 8; k++)
            chk(got[k], "R8", "in-flight lookup finished after count reduced", int'(got[k]), 1);

        // R9 counters hold when idle
        chk(int'(lookup_count) == total_rcvd, "R9", "lookup_count total", int'(lookup_count), total_rcvd);
        b0 = int'(busy_cycles);
        l0 = int'(lookup_count);
        repeat (20) @(negedge clk);
        chk(int'(busy_cycles) == b0, "R9", "busy_cycles holds when idle", int'(busy_cycles), b0);
        chk(int'(lookup_count) == l0, "R9", "lookup_count holds when idle", int'(lookup_count), l0);
        chk(b0 > 0 && b0 <= cyc, "R9", "busy_cycles within elapsed cycles", b0, cyc);
        finish_run();
    end
endmodule